// File: doc/BRIEF.md
# Serial Tag Search Cache

A small read-only cache that stores a parameterised number of single-word entries. Each entry has a valid flag, a full-address tag and one data word. A lookup does not use one comparator per entry. One comparator looks at one entry per clock, and a counter walks the entries in index order starting from entry 0. The search stops on the first valid entry whose tag equals the request address. That entry's word is returned as a hit. Because of this, the lookup time depends on where the matching entry sits in the array.

If the walk reaches the last entry with no match, the block raises a read request on an external memory port. It holds the request until the memory acknowledges with the data. It then returns that word as a miss response and stores it in an entry. The block takes the lowest-numbered empty entry if one exists. Otherwise a round-robin pointer chooses the entry to replace, and the pointer then moves on.

The processor side takes a request only while `req_ready` is high, which means the block is idle. The response is a one-cycle pulse on `rsp_valid`.

Top module: `serial_tag_cache`

## Requirements
- R1: A synchronous active-high reset clears every valid flag and the round-robin pointer. After reset, `req_ready` is 1 and `rsp_valid` and `mem_req` are 0.
- R2: A request is accepted only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from acceptance until the cycle in which `rsp_valid` is 1. `req_valid` or `req_addr` activity while busy has no effect on the current or later responses.
- R3: When the matching entry has index k, `rsp_valid` and `rsp_hit` are 1 exactly k+1 cycles after the accepting edge.
- R4: A hit returns the word stored with the matching tag on `rsp_data`, and the search stops at the first match.
- R5: An entry whose valid flag is clear never produces a hit, so every request after reset misses.
- R6: On a miss, `mem_req` rises exactly ENTRIES cycles after the accepting edge, with `mem_addr` equal to the request address. Both hold until the cycle in which `mem_ack` is 1.
- R7: On the edge where `mem_ack` is 1 with `mem_req` high, `mem_req` drops. In the next cycle `rsp_valid` is 1, `rsp_hit` is 0 and `rsp_data` equals `mem_data`. `rsp_valid` lasts one cycle.
- R8: A fetched word goes into the lowest-numbered invalid entry while one exists. The n-th distinct miss after reset therefore lands in entry n-1.
- R9: When all entries are valid, a miss replaces the entry named by the round-robin pointer, and the pointer then advances by one, wrapping after entry ENTRIES-1. The pointer starts at 0.
- R10: A reset during use empties the cache and returns the round-robin pointer to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor read request |
| req_addr | input | ADDR_W | Request address |
| req_ready | output | 1 | Block idle, request can be accepted |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | 1 when the response came from the cache |
| rsp_data | output | DATA_W | Returned word |
| mem_req | output | 1 | External memory read request |
| mem_addr | output | ADDR_W | External memory read address |
| mem_ack | input | 1 | Memory acknowledge, data valid in the same cycle |
| mem_data | input | DATA_W | Memory read data |

## Verification
A directed pass fills every entry from empty and then reads the entries forward and backward. This separates position-dependent hit latency from a fixed latency, and lowest-free placement from any other fill order. A ninth distinct address, followed by a re-read of the evicted one, shows that the round-robin victims follow the pointer. A mid-run reset shows that both the valid flags and the pointer are cleared. Random requests over an address pool somewhat larger than the cache, with random memory delays and stray requests while busy, mix hits, misses and evictions. These are checked against a bench model of tags, valid flags and pointer, which also confirms that busy-time requests are ignored.

// File: rtl/sts_pkg.sv
package sts_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_FETCH  = 2'd2
  } sts_state_e;
endpackage

// File: rtl/sts_store.sv
// Entry storage: tag and data arrays without reset (RAM style), valid flags with reset.
module sts_store #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  output logic [ENTRIES-1:0] valid_vec
);
  logic [ADDR_W-1:0] tag_mem  [ENTRIES];
  logic [DATA_W-1:0] data_mem [ENTRIES];
  logic [ENTRIES-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      data_mem[wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  assign rd_valid  = valid_q[rd_idx];
  assign rd_tag    = tag_mem[rd_idx];
  assign rd_data   = data_mem[rd_idx];
  assign valid_vec = valid_q;

  // R1
  reset_clears_valid_chk: assert property (@(posedge clk) $past(rst) |-> (valid_q == '0));
  // R8
  fill_sets_valid_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> valid_q[$past(wr_idx)]);
endmodule

// File: rtl/sts_victim.sv
// Chooses the entry to fill: lowest invalid first, else the round-robin pointer.
module sts_victim #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               fill,
  output logic [IDX_W-1:0]   victim_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             have_free;

  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        have_free = 1'b1;
        free_idx  = IDX_W'(i);
      end
    end
  end

  assign victim_idx = have_free ? free_idx : rr_q;

  always_ff @(posedge clk) begin
    if (rst) rr_q <= '0;
    else if (fill && !have_free) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
  end

  // R9
  rr_moves_on_evict_chk: assert property (@(posedge clk) disable iff (rst)
    (fill && (valid_vec == '1) && (ENTRIES > 1)) |=> (rr_q != $past(rr_q)));
  // R8
  rr_still_on_free_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (fill && (valid_vec != '1)) |=> $stable(rr_q));
endmodule

// File: rtl/sts_ctrl.sv
// Request FSM with the single tag comparator and the search counter.
module sts_ctrl
  import sts_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_data,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_tag,
  input  logic [DATA_W-1:0] rd_data,
  output logic              fill_en,
  output logic [ADDR_W-1:0] fill_tag,
  output logic [DATA_W-1:0] fill_data
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  sts_state_e        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic              match;

  assign match = (state_q == ST_SEARCH) && rd_valid && (rd_tag == addr_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      addr_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_data  <= '0;
      mem_req   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          idx_q   <= '0;
          state_q <= ST_SEARCH;
        end
        ST_SEARCH: if (match) begin
          rsp_valid <= 1'b1;
          rsp_hit   <= 1'b1;
          rsp_data  <= rd_data;
          state_q   <= ST_IDLE;
        end else if (idx_q == LAST) begin
          mem_req <= 1'b1;
          state_q <= ST_FETCH;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
        ST_FETCH: if (mem_ack) begin
          mem_req   <= 1'b0;
          rsp_valid <= 1'b1;
          rsp_hit   <= 1'b0;
          rsp_data  <= mem_data;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign mem_addr  = addr_q;
  assign rd_idx    = idx_q;
  assign fill_en   = (state_q == ST_FETCH) && mem_ack;
  assign fill_tag  = addr_q;
  assign fill_data = mem_data;

  // R7
  rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  // R6
  fetch_after_full_walk_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> ($past(idx_q) == LAST));
  // R6
  fetch_held_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  // R7
  miss_rsp_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> $past(mem_ack));
  // R2
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready);
endmodule

// File: rtl/serial_tag_cache.sv
module serial_tag_cache #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_data
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [IDX_W-1:0]   rd_idx, victim_idx;
  logic               rd_valid, fill_en;
  logic [ADDR_W-1:0]  rd_tag, fill_tag;
  logic [DATA_W-1:0]  rd_data, fill_data;
  logic [ENTRIES-1:0] valid_vec;

  sts_ctrl #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_data(rd_data),
    .fill_en(fill_en), .fill_tag(fill_tag), .fill_data(fill_data)
  );

  sts_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) store_i (
    .clk(clk), .rst(rst),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_data(rd_data),
    .wr_en(fill_en), .wr_idx(victim_idx), .wr_tag(fill_tag), .wr_data(fill_data),
    .valid_vec(valid_vec)
  );

  sts_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) victim_i (
    .clk(clk), .rst(rst),
    .valid_vec(valid_vec), .fill(fill_en), .victim_idx(victim_idx)
  );
endmodule

// File: tb/serial_tag_cache_tb_top.sv
module serial_tag_cache_tb_top;
  localparam int ENT = 8;
  localparam int AW  = 16;
  localparam int DW  = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_ready, rsp_valid, rsp_hit, mem_req;
  logic [DW-1:0] rsp_data;
  logic [AW-1:0] mem_addr;
  logic          mem_ack = 1'b0;
  logic [DW-1:0] mem_data = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  logic [AW-1:0] m_tag [ENT];
  bit            m_vld [ENT];
  int            m_rr;

  always #10 clk = ~clk;

  serial_tag_cache #(.ENTRIES(ENT), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data)
  );

  function automatic logic [DW-1:0] mem_word(logic [AW-1:0] a);
    return {a ^ 16'h5A3C, ~a};
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < ENT; i++) m_vld[i] = 1'b0;
    m_rr = 0;
  endfunction

  // returns hit index or -1
  function automatic int model_find(logic [AW-1:0] a);
    for (int i = 0; i < ENT; i++) if (m_vld[i] && m_tag[i] == a) return i;
    return -1;
  endfunction

  function automatic int model_victim();
    for (int i = 0; i < ENT; i++) if (!m_vld[i]) return i;
    return m_rr;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b0; mem_ack = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
    chk(req_ready == 1'b1, "R1", "req_ready after reset", 64'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 64'(rsp_valid), 0);
    chk(mem_req == 1'b0, "R1", "mem_req after reset", 64'(mem_req), 0);
  endtask

  // One access; we are at a negedge on entry. delay = memory wait cycles; noise = stray requests while busy.
  task automatic access(logic [AW-1:0] a, int delay, bit noise, logic [AW-1:0] noise_addr);
    int  hit_idx = model_find(a);
    int  cyc = 0;
    int  waited = 0;
    int  seen_req = -1;
    bit  acked = 1'b0;
    bit  got = 1'b0;
    chk(req_ready == 1'b1, "R2", "ready before request", 64'(req_ready), 1);
    req_valid = 1'b1;
    req_addr  = a;
    @(posedge clk);
    @(negedge clk);
    if (noise) req_addr = noise_addr; else req_valid = 1'b0;
    while (!got && cyc < 40) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      mem_ack = 1'b0;
      if (rsp_valid) begin
        got = 1'b1;
        req_valid = 1'b0;
      end else begin
        if (noise) chk(req_ready == 1'b0, "R2", "ready low while busy", 64'(req_ready), 0);
        if (mem_req && !acked) begin
          if (seen_req < 0) begin
            seen_req = cyc;
            chk(hit_idx < 0, "R5", "unexpected memory fetch", 64'(cyc), 0);
            chk(cyc == ENT, "R6", "mem_req rise cycle", 64'(cyc), ENT);
          end
          chk(mem_addr == a, "R6", "mem_addr", 64'(mem_addr), 64'(a));
          if (waited == delay) begin
            mem_ack  = 1'b1;
            mem_data = mem_word(a);
            acked    = 1'b1;
          end else waited++;
        end
      end
    end
    chk(got, "R2", "response arrived", 64'(got), 1);
    if (hit_idx >= 0) begin
      chk(rsp_hit == 1'b1, "R4", "rsp_hit on hit", 64'(rsp_hit), 1);
      chk(cyc == hit_idx + 1, "R3", "hit latency", 64'(cyc), 64'(hit_idx + 1));
      chk(rsp_data == mem_word(a), "R4", "hit data", 64'(rsp_data), 64'(mem_word(a)));
    end else begin
      int v = model_victim();
      chk(rsp_hit == 1'b0, "R5", "rsp_hit on miss", 64'(rsp_hit), 0);
      chk(cyc == ENT + delay + 1, "R7", "miss latency", 64'(cyc), 64'(ENT + delay + 1));
      chk(rsp_data == mem_word(a), "R7", "miss data", 64'(rsp_data), 64'(mem_word(a)));
      chk(mem_req == 1'b0, "R7", "mem_req dropped", 64'(mem_req), 0);
      if (v == m_rr && m_vld[v]) m_rr = (m_rr + 1) % ENT;
      m_tag[v] = a;
      m_vld[v] = 1'b1;
    end
    chk(req_ready == 1'b1, "R2", "ready in response cycle", 64'(req_ready), 1);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R7", "response is one cycle", 64'(rsp_valid), 0);
  endtask

  function automatic logic [AW-1:0] dir_addr(int i);
    return AW'(16'h1000 + i * 16'h0040);
  endfunction

  initial begin
    void'($urandom(32'd4711));
    do_reset();

    // R5 R8: fill from empty, every access misses, lands in lowest free entry
    for (int i = 0; i < ENT; i++) access(dir_addr(i), i % 3, 1'b0, '0);
    // R3 R4: forward then reverse, latency follows position
    for (int i = 0; i < ENT; i++) access(dir_addr(i), 0, 1'b0, '0);
    for (int i = ENT - 1; i >= 0; i--) access(dir_addr(i), 0, 1'b0, '0);
    // R9: ninth address evicts entry 0, then evicted address evicts entry 1
    access(dir_addr(ENT), 1, 1'b0, '0);
    access(dir_addr(0), 0, 1'b0, '0);
    access(dir_addr(2), 0, 1'b0, '0);
    access(dir_addr(1), 2, 1'b0, '0);
    // R2: stray requests while busy, including an address present in cache
    access(dir_addr(3), 0, 1'b1, dir_addr(4));
    access(16'hBEEF, 1, 1'b1, dir_addr(5));
    access(dir_addr(5), 0, 1'b0, '0);

    // R10: reset mid-use empties cache and pointer
    do_reset();
    access(dir_addr(2), 0, 1'b0, '0);
    for (int i = 0; i < ENT + 2; i++) access(AW'(16'h2000 + i), 0, 1'b0, '0);
    access(dir_addr(2), 0, 1'b0, '0);

    // random mix over a pool larger than the cache
    for (int n = 0; n < 300; n++) begin
      logic [AW-1:0] a  = AW'(16'h3000 + ($urandom % 12) * 16'h0100);
      logic [AW-1:0] na = AW'(16'h3000 + ($urandom % 12) * 16'h0100);
      access(a, int'($urandom % 4), bit'($urandom % 4 == 0), na);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule